// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the register side of a small Ethernet PHY management unit. It keeps sixteen 16-bit words that a host reaches through one 5-bit index, a write strobe with its data, and a read port that returns the indexed word in the same cycle. Six words carry meaning: a control word, a status word, two fixed identifier words, an advertised-ability word and a partner-ability word. The remaining ten are plain scratch storage.

A single `linkUp` input stands in for the line state. A change on it rewrites the link bit of the status word and the upper ability bits of the partner word. Writing the control word with its top bit set does not store the value. It reloads the whole bank and reapplies the current link state on that same clock edge. The serial management framing, real negotiation and the analog side sit outside the block.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After an asynchronous reset, indexes 0 (control), 1 (status), 2 (first identifier), 3 (second identifier) and 4 (advertisement) read 0x1000, 0x7848, 0x2000, 0x5C90 and 0x01E1. Index 5 (partner ability) and indexes 6 to 15 read 0. The link input is applied on the first clock edge after reset is released.
- R2: `rdData` shows the word at `regIdx` in the same cycle, with no clock in between. Any index from 16 to 31 reads 0.
- R3: A write to index 0 with bit 15 set stores nothing. On that edge every entry returns to its R1 value, and the current link level is applied on top as in R6 and R7. Bit 15 of index 0 never reads as 1.
- R4: Writes to indexes 1, 2 and 3 leave those words unchanged.
- R5: A write to index 0 with bit 15 clear, or to any index from 4 to 15, stores the full 16-bit value on the next edge. Writes to indexes 16 to 31 change no entry.
- R6: On the edge after `linkUp` rises, bit 2 of the status word is set and 0x01E1 is ORed into the partner word.
- R7: On the edge after `linkUp` falls, bit 2 of the status word is cleared and the partner word is ANDed with 0x01FF.
- R8: The link rule acts only on a change of `linkUp` or on a reset. While the level holds, a value written to the partner word is kept as written. When a write to the partner word and a link change fall on the same edge, the written value is masked by the link rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| regIdx | input | 5 | Register index for both read and write |
| wrEn | input | 1 | Write strobe for the indexed word |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Word at `regIdx`, combinational |
| linkUp | input | 1 | Line state, 1 when the link is up |

## Verification
On every cycle the assertions check four things: the identifier words keep their fixed values, control bit 15 stays clear, a soft reset lands the control and advertisement defaults, and stores to scratch entries arrive. They also check that the status link bit follows the link level one edge later, and that a link edge forces the partner mask. Some behaviour only the bench scenarios can show. These are the full reset image, reads of out-of-range indexes and ignored writes to read-only words. They also include partner values that survive a steady link, and the order in which a same-edge write and a link change combine. A behavioural model, compared on each clock, covers the sequences in between.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 16;
  localparam int IDX_W    = 5;
  localparam int SEL_W    = $clog2(NUM_REGS);

  localparam int IDX_CTRL    = 0;
  localparam int IDX_STAT    = 1;
  localparam int IDX_ID1     = 2;
  localparam int IDX_ID2     = 3;
  localparam int IDX_ADV     = 4;
  localparam int IDX_PARTNER = 5;

  localparam int SOFT_RST_BIT = 15;
  localparam int LINK_BIT     = 2;

  typedef logic [DATA_W-1:0] word_t;

  localparam word_t PARTNER_UP_OR   = 16'h01E1;
  localparam word_t PARTNER_DOWN_AND = 16'h01FF;

  // strobes from control to datapath
  typedef struct packed {
    logic softRst;
    logic wrStore;
    logic linkApply;
    logic linkLevel;
  } ctrlStrobe_t;

  function automatic word_t resetValue(int idx);
    case (idx)
      IDX_CTRL: return 16'h1000;
      IDX_STAT: return 16'h7848;
      IDX_ID1:  return 16'h2000;
      IDX_ID2:  return 16'h5C90;
      IDX_ADV:  return 16'h01E1;
      default:  return '0;
    endcase
  endfunction

  function automatic logic isReadOnly(int idx);
    return (idx == IDX_STAT) || (idx == IDX_ID1) || (idx == IDX_ID2);
  endfunction

  function automatic word_t applyLink(int idx, word_t v, logic up);
    word_t r;
    r = v;
    if (idx == IDX_STAT) r[LINK_BIT] = up;
    else if (idx == IDX_PARTNER) r = up ? (v | PARTNER_UP_OR) : (v & PARTNER_DOWN_AND);
    return r;
  endfunction
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  word_t                wrData,
  input  logic                 linkUp,
  output ctrlStrobe_t          strobe
);
  logic linkSeen;
  logic inRange;
  logic softRst;

  assign inRange = int'(wrIdx) < NUM_REGS;
  assign softRst = wrEn && (int'(wrIdx) == IDX_CTRL) && wrData[SOFT_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) linkSeen <= 1'b0;
    else        linkSeen <= linkUp;
  end

  always_comb begin
    strobe.softRst   = softRst;
    strobe.wrStore   = wrEn && inRange && !isReadOnly(int'(wrIdx)) && !softRst;
    strobe.linkApply = softRst || (linkUp != linkSeen);
    strobe.linkLevel = linkUp;
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrlStrobe_t                strobe,
  input  logic [IDX_W-1:0]           wrIdx,
  input  word_t                      wrData,
  input  logic [IDX_W-1:0]           rdIdx,
  output word_t                      rdData,
  output logic [NUM_REGS*DATA_W-1:0] regsFlat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    word_t entryQ;
    word_t entryNxt;

    always_comb begin
      entryNxt = entryQ;
      if (strobe.softRst) entryNxt = resetValue(g);
      else if (strobe.wrStore && (int'(wrIdx) == g)) entryNxt = wrData;
      if (strobe.linkApply) entryNxt = applyLink(g, entryNxt, strobe.linkLevel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entryQ <= resetValue(g);
      else        entryQ <= entryNxt;
    end

    assign regsFlat[g*DATA_W +: DATA_W] = entryQ;
  end

  always_comb begin
    if (int'(rdIdx) < NUM_REGS) rdData = regsFlat[int'(rdIdx[SEL_W-1:0])*DATA_W +: DATA_W];
    else                        rdData = '0;
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  regIdx,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        linkUp
);
  ctrlStrobe_t                strobe;
  logic [NUM_REGS*DATA_W-1:0] regsFlat;

  phy_mgmt_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrIdx  (regIdx),
    .wrData (wrData),
    .linkUp (linkUp),
    .strobe (strobe)
  );

  phy_mgmt_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrIdx    (regIdx),
    .wrData   (wrData),
    .rdIdx    (regIdx),
    .rdData   (rdData),
    .regsFlat (regsFlat)
  );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker
  import phy_mgmt_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [4:0]                 regIdx,
  input logic                       wrEn,
  input logic [15:0]                wrData,
  input logic                       linkUp,
  input logic [NUM_REGS*DATA_W-1:0] regsFlat
);
  word_t ctrlW, statW, id1W, id2W, advW, partW;
  assign ctrlW = regsFlat[IDX_CTRL*DATA_W +: DATA_W];
  assign statW = regsFlat[IDX_STAT*DATA_W +: DATA_W];
  assign id1W  = regsFlat[IDX_ID1*DATA_W +: DATA_W];
  assign id2W  = regsFlat[IDX_ID2*DATA_W +: DATA_W];
  assign advW  = regsFlat[IDX_ADV*DATA_W +: DATA_W];
  assign partW = regsFlat[IDX_PARTNER*DATA_W +: DATA_W];

  // record scratch stores for a one-edge-later comparison
  logic              pWr;
  logic [SEL_W-1:0]  pIdx;
  word_t             pData;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pWr <= 1'b0; pIdx <= '0; pData <= '0;
    end else begin
      pWr   <= wrEn && (int'(regIdx) >= 6) && (int'(regIdx) < NUM_REGS);
      pIdx  <= regIdx[SEL_W-1:0];
      pData <= wrData;
    end
  end

  p_id_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id1W == 16'h2000) && (id2W == 16'h5C90));

  p_ctrl_top_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlW[SOFT_RST_BIT] == 1'b0);

  p_soft_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regIdx == 5'd0 && wrData[15]) |=> (ctrlW == 16'h1000) && (advW == 16'h01E1));

  p_scratch_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pWr |-> (regsFlat[int'(pIdx)*DATA_W +: DATA_W] == pData));

  p_stat_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    linkUp |=> statW[LINK_BIT]);

  p_stat_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !linkUp |=> !statW[LINK_BIT]);

  p_partner_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linkUp) |=> ((partW & 16'h01E1) == 16'h01E1));

  p_partner_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(linkUp) |=> ((partW & 16'hFE00) == 16'h0000));
endmodule

bind phy_mgmt_regfile phy_mgmt_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .regIdx   (regIdx),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .linkUp   (linkUp),
  .regsFlat (regsFlat)
);

// File: tb/test_phy_mgmt_regfile.sv
`timescale 1ns/1ps
module test_phy_mgmt_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  regIdx = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        linkUp = 1'b0;
  logic [15:0] rdData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phy_mgmt_regfile i_phy_mgmt_regfile (
    .clk(clk), .rst_n(rst_n), .regIdx(regIdx), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .linkUp(linkUp)
  );

  // behavioural reference model
  int  mdl [16];
  bit  mdlSeen;

  function automatic void mdlDefaults();
    foreach (mdl[i]) mdl[i] = 0;
    mdl[0] = 'h1000; mdl[1] = 'h7848; mdl[2] = 'h2000; mdl[3] = 'h5C90; mdl[4] = 'h01E1;
  endfunction

  function automatic void mdlLink(bit up);
    if (up) begin mdl[1] = mdl[1] | 'h4; mdl[5] = mdl[5] | 'h01E1; end
    else    begin mdl[1] = mdl[1] & 'hFFFB; mdl[5] = mdl[5] & 'h01FF; end
  endfunction

  function automatic int mdlRead(int idx);
    return (idx < 16) ? mdl[idx] : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdlDefaults(); mdlSeen = 0;
    end else if (wrEn && regIdx == 0 && wrData[15]) begin
      mdlDefaults(); mdlLink(linkUp); mdlSeen = linkUp;
    end else begin
      if (wrEn && regIdx < 16 && !(regIdx inside {1, 2, 3})) mdl[regIdx] = wrData;
      if (linkUp != mdlSeen) mdlLink(linkUp);
      mdlSeen = linkUp;
    end
  end

  task automatic checkVal(string tag, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model (R2: combinational read)
  always @(negedge clk) begin
    if (rst_n && !finished) checkVal("R2 model", rdData, 16'(mdlRead(int'(regIdx))));
  end

  task automatic rd(int idx, logic [15:0] exp, string tag);
    @(posedge clk); #1;
    wrEn = 1'b0; regIdx = 5'(idx);
    @(negedge clk);
    checkVal(tag, rdData, exp);
  endtask

  task automatic wr(int idx, logic [15:0] data);
    @(posedge clk); #1;
    wrEn = 1'b1; regIdx = 5'(idx); wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic setLink(bit up);
    @(posedge clk); #1;
    linkUp = up;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset image
    rd(0, 16'h1000, "R1 ctrl");
    rd(1, 16'h7848, "R1 stat");
    rd(2, 16'h2000, "R1 id1");
    rd(3, 16'h5C90, "R1 id2");
    rd(4, 16'h01E1, "R1 adv");
    rd(5, 16'h0000, "R1 partner");
    rd(9, 16'h0000, "R1 scratch");
    // R2 out of range read
    rd(20, 16'h0000, "R2 high index");

    // R4 read-only words
    wr(2, 16'h1234); rd(2, 16'h2000, "R4 id1");
    wr(3, 16'hFFFF); rd(3, 16'h5C90, "R4 id2");
    wr(1, 16'hFFFF); rd(1, 16'h7848, "R4 stat");

    // R5 stores
    wr(4, 16'h0021);  rd(4, 16'h0021, "R5 adv");
    wr(12, 16'hBEEF); rd(12, 16'hBEEF, "R5 scratch");
    wr(0, 16'h3100);  rd(0, 16'h3100, "R5 ctrl");
    wr(15, 16'hFFFF); rd(15, 16'hFFFF, "R5 last index");
    wr(17, 16'hAAAA); rd(17, 16'h0000, "R5 high write");
    rd(1, 16'h7848, "R5 high write no alias");

    // R6 link rise
    setLink(1);
    rd(1, 16'h784C, "R6 stat bit");
    rd(5, 16'h01E1, "R6 partner");

    // R8 steady link keeps written partner
    wr(5, 16'hF203); rd(5, 16'hF203, "R8 steady");

    // R7 link fall
    setLink(0);
    rd(5, 16'h0003, "R7 partner");
    rd(1, 16'h7848, "R7 stat bit");

    // R3 soft reset, link down
    wr(0, 16'h8000);
    rd(0, 16'h1000, "R3 ctrl");
    rd(4, 16'h01E1, "R3 adv");
    rd(12, 16'h0000, "R3 scratch");
    rd(5, 16'h0000, "R3 partner");

    // R3 soft reset, link up
    setLink(1);
    wr(12, 16'h5555);
    wr(0, 16'h9234);
    rd(0, 16'h1000, "R3 ctrl value not kept");
    rd(1, 16'h784C, "R3 stat link");
    rd(5, 16'h01E1, "R3 partner link");
    rd(12, 16'h0000, "R3 scratch up");

    // R8 write and link fall on the same edge
    @(posedge clk); #1;
    linkUp = 1'b0; wrEn = 1'b1; regIdx = 5'd5; wrData = 16'hFFFF;
    @(posedge clk); #1;
    wrEn = 1'b0;
    rd(5, 16'h01FF, "R8 same edge");
    rd(1, 16'h7848, "R8 same edge stat");

    // R1 asynchronous reset with link up
    setLink(1);
    wr(7, 16'h0707);
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(1, 16'h784C, "R1 link after reset");
    rd(5, 16'h01E1, "R1 partner after reset");
    rd(7, 16'h0000, "R1 scratch after reset");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule